// File: doc/BRIEF.md
# Double-Buffered BCD Clock Calendar

This block keeps time of day and calendar date in packed BCD, 24-hour form: seconds, minutes, hours, day of week, day of month, month, year and century. A prescaler divides a stream of oscillator pulses, one per oscillator cycle of a nominal 32.768 kHz source, into a once-per-second advance. The block holds two copies of the time. The working copy always counts. The host-facing copy is what the host reads and writes over a byte-wide register port with a 4-bit address and separate read and write enables.

While neither hold bit in the control register is set, the host copy follows the working copy on every system clock. Setting the read-hold bit freezes the host copy, so a multi-byte read sees one coherent instant while the working copy keeps counting. Setting the write-hold bit also freezes the host copy and opens it to host writes. Clearing the write-hold bit then moves every field into the working copy in a single clock and restarts the second prescaler. Month lengths, including February in leap years, are handled automatically.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the clock is stopped (bit 7 of register 9h reads 1), both hold bits are 0, the frequency-test bit is 0, and the time reads 00:00:00, day 01, date 01, month 01, year 00, century 00.
- R2: Register 8h reads {write-hold bit 7, read-hold bit 6, century bits 5:0}; 9h seconds; Ah minutes; Bh hours; Ch day in bits 2:0; Dh date; Eh month; Fh year. Field bits outside each field read 0. Registers 0h to 7h read 00 and writes to them change nothing. rdData is 00 whenever rdEn is low.
- R3: Bit 7 of register 9h is the stop bit. A write to 9h sets it from wrData[7] in any mode. While it is 1 the time does not advance and the prescaler stays at zero.
- R4: With the stop bit at 0, the working time advances by one second on the TICKS_PER_SEC-th oscTick pulse counted since the prescaler was last at zero.
- R5: Each field rolls over to its minimum in the same cycle as the advance that carries into it. The ranges are seconds and minutes 00 to 59, hours 00 to 23, day 01 to 07, date 01 to the month length, month 01 to 12, year 00 to 99 and century 00 to 39. The day of week and the date both advance when the hours roll over, and the century advances when the year rolls from 99 to 00.
- R6: Months 04, 06, 09 and 11 have 30 days, and the other valid months have 31. February has 29 days when the BCD year is divisible by four and 28 days otherwise.
- R7: A field that holds a non-BCD nibble or a value above its maximum goes to its minimum on its next advance and carries into the next field.
- R8: While the read-hold bit (8h bit 6) is 1, the host copy keeps the value captured at the edge that set the bit, and the working copy keeps counting. Two cycles after the bit is cleared, a read returns the current working time.
- R9: Writes to registers 8h to Fh change host-copy fields only while the write-hold bit is 1 before the write. Otherwise those field bits are ignored. The stop bit, the frequency-test bit and the hold bits are excepted.
- R10: A write to 8h with bit 7 at 0 while the write-hold bit is 1 copies the host copy into the working copy in one cycle, takes the century from wrData[5:0] of that same write, and resets the prescaler.
- R11: Bit 6 of register Ch is the frequency-test enable. Any write to Ch sets it from wrData[6], it drives freqTestEn, and it reads back in bit 6 of Ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle pulse per oscillator period |
| addr | input | 4 | Register select |
| wrEn | input | 1 | Write enable for the addressed register |
| rdEn | input | 1 | Read enable; rdData is zero when low |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data of the addressed register |
| freqTestEn | output | 1 | Frequency-test enable bit |

## Verification
The hardest situations to reach from the ports are the deep carries: the year and century rollovers and the February boundary cannot be reached by counting seconds within a bench's cycle budget. The stimulus gets there with the write-hold load. It loads 23:59:59 on the last day of a month or year, clears the write-hold bit, and then feeds exactly one second of oscillator pulses, with the prescaler divisor reduced to four. The same load path plants invalid BCD values to exercise the forced wrap. A cycle-level reference model checks every read against the hold semantics, including the one-cycle lag of the host copy.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);

  // host copy / working copy slot numbers (equal to addr[2:0] of the time registers)
  localparam logic [IDX_W-1:0] IDX_CENT  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SEC   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MIN   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_HOUR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DAY   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DATE  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MONTH = 3'd6;
  localparam logic [IDX_W-1:0] IDX_YEAR  = 3'd7;

  localparam logic [3:0] ADDR_CTRL = 4'h8;
  localparam logic [3:0] ADDR_SEC  = 4'h9;
  localparam logic [3:0] ADDR_DAY  = 4'hC;

  typedef struct packed {
    logic             advance;  // one-second step of the working copy
    logic             load;     // host copy -> working copy
    logic             refresh;  // working copy -> host copy
    logic             hostWr;   // host write into a host-copy field
    logic [IDX_W-1:0] wrIdx;
    logic [7:0]       wrData;
  } calStrobes_t;

  function automatic logic [7:0] fieldMask(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_SEC, IDX_MIN:              return 8'h7F;
      IDX_CENT, IDX_HOUR, IDX_DATE:  return 8'h3F;
      IDX_DAY:                       return 8'h07;
      IDX_MONTH:                     return 8'h1F;
      default:                       return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] fieldLo(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_DAY, IDX_DATE, IDX_MONTH: return 8'h01;
      default:                      return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fieldHi(input logic [IDX_W-1:0] idx,
                                         input logic [7:0] monthLen);
    case (idx)
      IDX_CENT:          return 8'h39;
      IDX_SEC, IDX_MIN:  return 8'h59;
      IDX_HOUR:          return 8'h23;
      IDX_DAY:           return 8'h07;
      IDX_DATE:          return monthLen;
      IDX_MONTH:         return 8'h12;
      default:           return 8'h99;
    endcase
  endfunction

  function automatic logic isLeapBcd(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeapBcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // {carry, next}: wraps to lo when invalid or at/above hi
  function automatic logic [8:0] bcdStep(input logic [7:0] v,
                                         input logic [7:0] lo,
                                         input logic [7:0] hi);
    if ((v[3:0] > 4'd9) || (v[7:4] > 4'd9) || (v >= hi)) return {1'b1, lo};
    if (v[3:0] == 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/rtcc_ctrl.sv
module rtcc_ctrl
  import rtcc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscTick,
  input  logic [3:0]  addr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output calStrobes_t stb,
  output logic        oscStop,
  output logic        ftEn,
  output logic        wHold,
  output logic        rHold
);

  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] preCnt;
  logic             ctrlWr;
  logic             loadNow;
  logic             secTick;

  assign ctrlWr  = wrEn && (addr == ADDR_CTRL);
  assign loadNow = ctrlWr && wHold && !wrData[7];
  assign secTick = oscTick && (preCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (oscStop || loadNow) begin
      preCnt <= '0;
    end else if (oscTick) begin
      preCnt <= (preCnt == CNT_LAST) ? '0 : preCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wHold   <= 1'b0;
      rHold   <= 1'b0;
      oscStop <= 1'b1;
      ftEn    <= 1'b0;
    end else begin
      if (ctrlWr) begin
        wHold <= wrData[7];
        rHold <= wrData[6];
      end
      if (wrEn && (addr == ADDR_SEC)) oscStop <= wrData[7];
      if (wrEn && (addr == ADDR_DAY)) ftEn    <= wrData[6];
    end
  end

  always_comb begin
    stb.advance = secTick && !oscStop && !loadNow;
    stb.load    = loadNow;
    stb.refresh = !wHold && !rHold;
    stb.hostWr  = wrEn && wHold && addr[3];
    stb.wrIdx   = addr[IDX_W-1:0];
    stb.wrData  = wrData;
  end

endmodule

// File: rtl/rtcc_datapath.sv
module rtcc_datapath
  import rtcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  calStrobes_t stb,
  input  logic        rdEn,
  input  logic [3:0]  addr,
  input  logic        oscStop,
  input  logic        ftEn,
  input  logic        wHold,
  input  logic        rHold,
  output logic [7:0]  rdData
);

  logic [7:0]      workReg [NREG];
  logic [7:0]      hostReg [NREG];
  logic [8:0]      stepRes [NREG];
  logic [NREG-1:0] carry;
  logic [NREG-1:0] fieldEn;
  logic [7:0]      monthLen;

  assign monthLen = monthDays(workReg[IDX_MONTH], workReg[IDX_YEAR]);

  for (genvar g = 0; g < NREG; g++) begin : gStep
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    assign stepRes[g] = bcdStep(workReg[g], fieldLo(GI), fieldHi(GI, monthLen));
    assign carry[g]   = stepRes[g][8];
  end

  // carry chain: sec -> min -> hour -> {day, date} -> month -> year -> century
  always_comb begin
    fieldEn            = '0;
    fieldEn[IDX_SEC]   = 1'b1;
    fieldEn[IDX_MIN]   = carry[IDX_SEC];
    fieldEn[IDX_HOUR]  = fieldEn[IDX_MIN]  && carry[IDX_MIN];
    fieldEn[IDX_DAY]   = fieldEn[IDX_HOUR] && carry[IDX_HOUR];
    fieldEn[IDX_DATE]  = fieldEn[IDX_DAY];
    fieldEn[IDX_MONTH] = fieldEn[IDX_DATE]  && carry[IDX_DATE];
    fieldEn[IDX_YEAR]  = fieldEn[IDX_MONTH] && carry[IDX_MONTH];
    fieldEn[IDX_CENT]  = fieldEn[IDX_YEAR]  && carry[IDX_YEAR];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) workReg[i] <= fieldLo(IDX_W'(i));
    end else if (stb.load) begin
      for (int i = 0; i < NREG; i++) workReg[i] <= hostReg[i];
      workReg[IDX_CENT] <= stb.wrData & fieldMask(IDX_CENT);
    end else if (stb.advance) begin
      for (int i = 0; i < NREG; i++)
        if (fieldEn[i]) workReg[i] <= stepRes[i][7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) hostReg[i] <= fieldLo(IDX_W'(i));
    end else if (stb.refresh) begin
      for (int i = 0; i < NREG; i++) hostReg[i] <= workReg[i];
    end else if (stb.hostWr) begin
      hostReg[stb.wrIdx] <= stb.wrData & fieldMask(stb.wrIdx);
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (rdEn) begin
      case (addr)
        4'h8:                      rdData = {wHold, rHold, hostReg[IDX_CENT][5:0]};
        4'h9:                      rdData = {oscStop, hostReg[IDX_SEC][6:0]};
        4'hC:                      rdData = {1'b0, ftEn, 3'b000, hostReg[IDX_DAY][2:0]};
        4'hA, 4'hB, 4'hD, 4'hE, 4'hF: rdData = hostReg[addr[IDX_W-1:0]];
        default:                   rdData = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import rtcc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic [3:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       freqTestEn
);

  calStrobes_t stb;
  logic        oscStop;
  logic        ftEn;
  logic        wHold;
  logic        rHold;

  rtcc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .stb(stb), .oscStop(oscStop), .ftEn(ftEn),
    .wHold(wHold), .rHold(rHold)
  );

  rtcc_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdEn(rdEn), .addr(addr),
    .oscStop(oscStop), .ftEn(ftEn), .wHold(wHold), .rHold(rHold),
    .rdData(rdData)
  );

  assign freqTestEn = ftEn;

endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker #(
  parameter int TICKS_PER_SEC = 32768
) (
  input logic       clk,
  input logic       rstN,
  input logic       oscTick,
  input logic [3:0] addr,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       freqTestEn,
  input logic       oscStop,
  input logic       wHold,
  input logic       rHold,
  input logic       advance,
  input logic       load
);

  int tickSeen;

  always_ff @(posedge clk) begin
    if (!rstN || load || oscStop) tickSeen <= 0;
    else if (oscTick) tickSeen <= (tickSeen == TICKS_PER_SEC - 1) ? 0 : tickSeen + 1;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 8'h00); // R2

  AST_LOW_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addr[3]) |-> rdData == 8'h00); // R2

  AST_STOP_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    oscStop |-> !advance); // R3

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> (oscTick && tickSeen == TICKS_PER_SEC - 1)); // R4

  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && addr == $past(addr) && addr >= 4'h9 &&
     rHold && $past(rHold) && !$past(wrEn)) |-> $stable(rdData)); // R8

  AST_WRITE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && addr == $past(addr) && addr >= 4'h9 &&
     wHold && $past(wHold) && !$past(wrEn)) |-> $stable(rdData)); // R9

  AST_LOAD_CLEARS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !wHold); // R10

  AST_FT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 4'hC && wrData[6] != freqTestEn) |=> $stable(freqTestEn)); // R11

endmodule

bind bcd_clock_calendar rtcc_checker #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk(clk), .rstN(rstN), .oscTick(oscTick), .addr(addr), .wrEn(wrEn),
  .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .freqTestEn(freqTestEn),
  .oscStop(oscStop), .wHold(wHold), .rHold(rHold),
  .advance(stb.advance), .load(stb.load)
);

// File: tb/bcd_clock_calendar_bench.sv
module bcd_clock_calendar_bench;

  localparam int TICKS = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       oscTick;
  logic [3:0] addr;
  logic       wrEn;
  logic       rdEn;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       freqTestEn;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  int  rot = 0;

  // reference state, slot = addr[2:0]: 0 cent,1 sec,2 min,3 hour,4 day,5 date,6 month,7 year
  bit [7:0] mWork [8];
  bit [7:0] mHost [8];
  bit mW, mR, mStop, mFt;
  int mCnt;

  always #5 clk = ~clk;

  bcd_clock_calendar #(.TICKS_PER_SEC(TICKS)) u_bcd_clock_calendar (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .freqTestEn(freqTestEn)
  );

  function automatic int dec(bit [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic bit [7:0] bcd(int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic bit wraps(bit [7:0] v, int hi);
    return (v[3:0] > 9) || (v[7:4] > 9) || (dec(v) >= hi);
  endfunction

  function automatic bit [7:0] after(bit [7:0] v, int lo, int hi);
    return wraps(v, hi) ? bcd(lo) : bcd(dec(v) + 1);
  endfunction

  function automatic bit [7:0] maskOf(int slot);
    case (slot)
      1, 2: return 8'h7F;
      0, 3, 5: return 8'h3F;
      4: return 8'h07;
      6: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int daysIn();
    int m = dec(mWork[6]);
    if (m == 2) return (dec(mWork[7]) % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic modelSecond();
    bit c;
    int d;
    c = wraps(mWork[1], 59); mWork[1] = after(mWork[1], 0, 59);
    if (c) begin
      c = wraps(mWork[2], 59); mWork[2] = after(mWork[2], 0, 59);
      if (c) begin
        c = wraps(mWork[3], 23); mWork[3] = after(mWork[3], 0, 23);
        if (c) begin
          d = daysIn();
          mWork[4] = after(mWork[4], 1, 7);
          c = wraps(mWork[5], d); mWork[5] = after(mWork[5], 1, d);
          if (c) begin
            c = wraps(mWork[6], 12); mWork[6] = after(mWork[6], 1, 12);
            if (c) begin
              c = wraps(mWork[7], 99); mWork[7] = after(mWork[7], 0, 99);
              if (c) mWork[0] = after(mWork[0], 0, 39);
            end
          end
        end
      end
    end
  endtask

  function automatic bit [7:0] modelRead(bit [3:0] a);
    case (a)
      4'h8: return {mW, mR, mHost[0][5:0]};
      4'h9: return {mStop, mHost[1][6:0]};
      4'hC: return {1'b0, mFt, 3'b000, mHost[4][2:0]};
      4'hA, 4'hB, 4'hD, 4'hE, 4'hF: return mHost[a[2:0]];
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      mWork[i] = (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
      mHost[i] = mWork[i];
    end
    mW = 0; mR = 0; mStop = 1; mFt = 0; mCnt = 0;
  endtask

  task automatic modelStep(bit we, bit [3:0] a, bit [7:0] d, bit ot);
    bit [7:0] oldWork [8];
    bit [7:0] oldHost [8];
    bit ld, adv;
    oldWork = mWork; oldHost = mHost;
    ld  = we && a == 4'h8 && mW && !d[7];
    adv = ot && !mStop && !ld && mCnt == TICKS - 1;
    if (mStop || ld) mCnt = 0;
    else if (ot) mCnt = (mCnt + 1) % TICKS;
    if (!mW && !mR) mHost = oldWork;
    else if (we && mW && a >= 4'h8) mHost[a[2:0]] = d & maskOf(int'(a[2:0]));
    if (ld) begin
      mWork = oldHost;
      mWork[0] = d & 8'h3F;
    end else if (adv) modelSecond();
    if (we && a == 4'h8) begin mW = d[7]; mR = d[6]; end
    if (we && a == 4'h9) mStop = d[7];
    if (we && a == 4'hC) mFt = d[6];
  endtask

  task automatic chk(string tag, bit [7:0] act, bit [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one clock: drive, sample mid-cycle, advance the model at the edge
  task automatic cyc(bit we, bit re, bit [3:0] a, bit [7:0] d, bit ot,
                     string tag, int expConst = -1);
    wrEn = we; rdEn = re; addr = a; wrData = d; oscTick = ot;
    #2;
    chk({tag, " (model)"}, rdData, re ? modelRead(a) : 8'h00);
    if (expConst >= 0) chk(tag, rdData, expConst[7:0]);
    chk("R11 freqTestEn (model)", {7'd0, freqTestEn}, {7'd0, mFt});
    @(posedge clk);
    modelStep(we, a, d, ot);
    @(negedge clk);
  endtask

  task automatic idle(int n, bit ot, string tag);
    for (int i = 0; i < n; i++) begin
      cyc(0, 1, 4'(8 + rot % 8), 8'h00, ot, tag);
      rot++;
    end
  endtask

  task automatic rd(bit [3:0] a, int exp, string tag);
    cyc(0, 1, a, 8'h00, 0, tag, exp);
  endtask

  task automatic wr(bit [3:0] a, bit [7:0] d, string tag);
    cyc(1, 0, a, d, 0, tag);
  endtask

  task automatic oneSecond();
    idle(TICKS, 1, "R4 counting");
    idle(1, 0, "R4 settle");
  endtask

  task automatic loadTime(bit [7:0] s, bit [7:0] mi, bit [7:0] h, bit [7:0] dw,
                          bit [7:0] dt, bit [7:0] mo, bit [7:0] y, bit [7:0] c);
    wr(4'h8, 8'h80, "R9 open write hold");
    wr(4'h9, s,  "R9 sec");
    wr(4'hA, mi, "R9 min");
    wr(4'hB, h,  "R9 hour");
    wr(4'hC, dw, "R9 day");
    wr(4'hD, dt, "R9 date");
    wr(4'hE, mo, "R9 month");
    wr(4'hF, y,  "R9 year");
    wr(4'h8, {2'b00, c[5:0]}, "R10 transfer");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wrEn = 0; rdEn = 0; addr = 4'h0; wrData = 8'h00; oscTick = 0;
    rstN = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1 reset state
    rd(4'h8, 8'h00, "R1 control");
    rd(4'h9, 8'h80, "R1 seconds stopped");
    rd(4'hA, 8'h00, "R1 minutes");
    rd(4'hB, 8'h00, "R1 hours");
    rd(4'hC, 8'h01, "R1 day");
    rd(4'hD, 8'h01, "R1 date");
    rd(4'hE, 8'h01, "R1 month");
    rd(4'hF, 8'h00, "R1 year");
    chk("R1 freqTestEn", {7'd0, freqTestEn}, 8'h00);

    // R3 stopped clock ignores pulses
    idle(6, 1, "R3 stopped");
    rd(4'h9, 8'h80, "R3 no advance while stopped");
    wr(4'h9, 8'h00, "R3 start");
    rd(4'h9, 8'h00, "R3 started");
    idle(TICKS - 1, 1, "R4 partial");
    rd(4'h9, 8'h00, "R4 not yet a second");
    idle(1, 1, "R4 last pulse");
    idle(1, 0, "R4 settle");
    rd(4'h9, 8'h01, "R4 one second");

    // R9 field write without hold is ignored
    wr(4'h9, 8'h25, "R9 write without hold");
    rd(4'h9, 8'h01, "R9 seconds unchanged");

    // R3 stopping a running clock
    wr(4'h9, 8'h80, "R3 stop");
    idle(2 * TICKS, 1, "R3 stopped run");
    rd(4'h9, 8'h81, "R3 frozen at 01");

    // R2 low addresses and idle read
    wr(4'h3, 8'hFF, "R2 low write");
    rd(4'h3, 8'h00, "R2 low read");
    cyc(0, 0, 4'h9, 8'h00, 0, "R2 rdEn low", 8'h00);

    // R5 full rollover through day-of-week and century
    loadTime(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h19);
    rd(4'h8, 8'h19, "R10 century from clearing write");
    rd(4'h9, 8'h59, "R10 seconds loaded");
    idle(TICKS - 1, 1, "R10 restart partial");
    idle(1, 0, "R10 settle");
    rd(4'h9, 8'h59, "R10 prescaler restarted");
    idle(1, 1, "R10 last pulse");
    idle(1, 0, "R5 settle");
    rd(4'h9, 8'h00, "R5 sec wrap");
    rd(4'hA, 8'h00, "R5 min wrap");
    rd(4'hB, 8'h00, "R5 hour wrap");
    rd(4'hC, 8'h01, "R5 day 07 to 01");
    rd(4'hD, 8'h01, "R5 date wrap");
    rd(4'hE, 8'h01, "R5 month wrap");
    rd(4'hF, 8'h00, "R5 year wrap");
    rd(4'h8, 8'h20, "R5 century carry");

    // R6 month lengths
    loadTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
    oneSecond();
    rd(4'hD, 8'h29, "R6 leap February 29");
    rd(4'hE, 8'h02, "R6 leap month kept");
    rd(4'hC, 8'h04, "R5 day advance");
    loadTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
    oneSecond();
    rd(4'hD, 8'h01, "R6 common February end");
    rd(4'hE, 8'h03, "R6 to March");
    loadTime(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23, 8'h20);
    oneSecond();
    rd(4'hD, 8'h01, "R6 30-day month end");
    rd(4'hE, 8'h05, "R6 to May");

    // R7 invalid BCD wraps and carries
    loadTime(8'h5A, 8'h10, 8'h05, 8'h01, 8'h10, 8'h06, 8'h23, 8'h20);
    oneSecond();
    rd(4'h9, 8'h00, "R7 invalid seconds wrap");
    rd(4'hA, 8'h11, "R7 carry into minutes");
    loadTime(8'h59, 8'h7F, 8'h05, 8'h01, 8'h10, 8'h06, 8'h23, 8'h20);
    oneSecond();
    rd(4'hA, 8'h00, "R7 invalid minutes wrap");
    rd(4'hB, 8'h06, "R7 carry into hours");

    // R8 read hold snapshot
    wr(4'h8, 8'h40, "R8 set read hold");
    oneSecond();
    oneSecond();
    wr(4'h9, 8'h33, "R9 write under read hold");
    rd(4'h9, 8'h00, "R8 snapshot seconds");
    rd(4'hB, 8'h06, "R8 snapshot hours");
    rd(4'h8, 8'h60, "R8 control readback");
    wr(4'h8, 8'h00, "R8 release");
    idle(1, 0, "R8 settle");
    rd(4'h9, 8'h02, "R8 resumed shows working time");

    // R5 century wrap
    loadTime(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h39);
    oneSecond();
    rd(4'h8, 8'h00, "R5 century 39 to 00");
    rd(4'hF, 8'h00, "R5 year 99 to 00");

    // R11 frequency-test bit
    wr(4'hC, 8'h40, "R11 set");
    chk("R11 freqTestEn high", {7'd0, freqTestEn}, 8'h01);
    rd(4'hC, 8'h41, "R11 readback with day");
    wr(4'hC, 8'h05, "R11 clear without hold");
    chk("R11 freqTestEn low", {7'd0, freqTestEn}, 8'h00);
    rd(4'hC, 8'h01, "R11 day kept");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule